// File: doc/BRIEF.md
# Ring Oscillator Wrap Counter with Hysteretic Input Filter

This block keeps the coarse part of a gated ring oscillator's phase. It counts whole rotations of the ring by counting the rising transitions of one chosen stage. A single extra count shifts the conversion result by at least twice the stage count, and that error is not noise shaped. The block must therefore never count twice when the ring is frozen with a stage sitting at its switching threshold.

Two stage signals are observed. The first is the counted tap. The second is a lead tap that switches shortly before it, in the same direction. Both taps are synchronized to the sampling clock. A filtered level takes the value of the two taps while they agree and holds its last value while they disagree. A tap that dithers alone therefore cannot move the filtered level. The counter advances on each rising edge of the filtered level. It is a free-running counter whose overflow flag toggles on every wrap, so downstream differencing can extend the range.

Top module: `ring_wrap_counter`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `wrap_count` is 0 and `wrap_ovf` is 0.
- R2: When both taps change from 0 to 1 together, with the filtered level low, `wrap_count` rises by one on the third rising clock edge after the change. It is unchanged after the first and second edges.
- R3: When the synchronized taps agree, the filtered level takes their common value on the next edge. The count advances only on an edge where the filtered level goes from 0 to 1.
- R4: When the synchronized taps differ, the filtered level holds. A tap pair that alternates between 00 and 10, between 00 and 01, or between 11 and 10 or 01 never changes `wrap_count`.
- R5: `wrap_count` only ever stays the same or rises by exactly one (modulo 2^CNT_W) from one clock to the next.
- R6: `wrap_count` counts modulo 2^CNT_W. `wrap_ovf` toggles on exactly the edge where the count goes from all ones to 0, and never on any other edge.
- R7: After reset is released, the first SYNC_STAGES+1 edges load the filtered level from the agreed tap level without counting. Taps held at 11 through and after reset give no count.
- R8: A clean rotation of the (lead, main) pair, 00 → 10 → 11 → 01 → 00, adds exactly one to `wrap_count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| tap_lead | input | 1 | Stage that switches just before the counted stage |
| tap_main | input | 1 | Counted stage |
| wrap_count | output | CNT_W | Rotation count modulo 2^CNT_W |
| wrap_ovf | output | 1 | Toggles on each count wrap |

## Verification
Each tap change reaches the synchronizer output after two edges. The filtered level, the count and the overflow flag change on the third edge. The bench sets the taps on the falling edge and advances a reference model from the requirements on every rising edge. It compares `wrap_count` and `wrap_ovf` at the next falling edge, so each compare sees the result of the edge just before it. Directed checks for latency, hovering, priming and wrap count a fixed number of edges before sampling.

// File: rtl/ring_wrap_pkg.sv
package ring_wrap_pkg;

    localparam int unsigned DEF_CNT_W       = 8;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // State of the hysteretic filter: held level and arming flag
    typedef struct packed {
        logic level;
        logic armed;
    } filt_state_t;

endpackage

// File: rtl/rwc_sync.sv
module rwc_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < int'(STAGES); s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/rwc_hyst_filter.sv
module rwc_hyst_filter
    import ring_wrap_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lead_s,
    input  logic main_s,
    output logic level,
    output logic armed,
    output logic rise
);

    localparam int unsigned FILL_W   = $clog2(SYNC_STAGES + 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(SYNC_STAGES);

    filt_state_t         st_d, st_q;
    logic [FILL_W-1:0]   fill_d, fill_q;

    always_comb begin
        st_d   = st_q;
        fill_d = fill_q;
        if (lead_s == main_s) begin
            st_d.level = main_s;
        end
        if (fill_q != FILL_LAST) begin
            fill_d = fill_q + 1'b1;
        end
        if (fill_q == FILL_LAST) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            fill_q <= '0;
        end else begin
            st_q   <= st_d;
            fill_q <= fill_d;
        end
    end

    assign level = st_q.level;
    assign armed = st_q.armed;
    assign rise  = st_q.armed & ~st_q.level & st_d.level;

endmodule

// File: rtl/rwc_wrap_counter.sv
module rwc_wrap_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (&st_q.cnt) begin
                st_d.ovf = ~st_q.ovf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;

endmodule

// File: rtl/ring_wrap_counter.sv
module ring_wrap_counter
    import ring_wrap_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_lead,
    input  logic             tap_main,
    output logic [CNT_W-1:0] wrap_count,
    output logic             wrap_ovf
);

    logic [1:0] taps_sync;
    logic       lead_sync;
    logic       main_sync;
    logic       filt_level;
    logic       filt_armed;
    logic       filt_rise;

    rwc_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({tap_lead, tap_main}),
        .sync_out (taps_sync)
    );

    assign lead_sync = taps_sync[1];
    assign main_sync = taps_sync[0];

    rwc_hyst_filter #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .lead_s (lead_sync),
        .main_s (main_sync),
        .level  (filt_level),
        .armed  (filt_armed),
        .rise   (filt_rise)
    );

    rwc_wrap_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (filt_rise),
        .count (wrap_count),
        .ovf   (wrap_ovf)
    );

endmodule

// File: rtl/ring_wrap_counter_chk.sv
module ring_wrap_counter_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lead_s,
    input logic             main_s,
    input logic             filt,
    input logic             armed,
    input logic [CNT_W-1:0] wrap_count,
    input logic             wrap_ovf
);

    a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_s == main_s) |=> (filt == $past(main_s)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_s != main_s) |=> $stable(filt));

    a_r3_count_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !filt && lead_s && main_s) |=>
            (wrap_count == CNT_W'($past(wrap_count) + 1'b1)));

    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(wrap_count) ||
                  wrap_count == CNT_W'($past(wrap_count) + 1'b1)));

    a_r6_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wrap_ovf) |-> (wrap_count == '0 && $past(wrap_count) == '1));

    a_r7_no_count_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(wrap_count));

endmodule

bind ring_wrap_counter ring_wrap_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lead_s     (lead_sync),
    .main_s     (main_sync),
    .filt       (filt_level),
    .armed      (filt_armed),
    .wrap_count (wrap_count),
    .wrap_ovf   (wrap_ovf)
);

// File: tb/ring_wrap_counter_test.sv
`timescale 1ns/1ps
module ring_wrap_counter_test;

    localparam int CNT_W = 8;
    localparam int SYNC  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tap_lead = 1'b0;
    logic             tap_main = 1'b0;
    logic [CNT_W-1:0] wrap_count;
    logic             wrap_ovf;

    int checks = 0;
    int failures = 0;

    // reference model state, advanced per rising edge from the requirements
    logic [SYNC-1:0]  m_lead, m_main;
    logic             m_filt, m_armed;
    int               m_edges;
    logic [CNT_W-1:0] m_cnt;
    logic             m_ovf;

    always #4 clk = ~clk;

    ring_wrap_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .tap_lead(tap_lead), .tap_main(tap_main),
        .wrap_count(wrap_count), .wrap_ovf(wrap_ovf)
    );

    task automatic model_reset();
        m_lead = '0; m_main = '0; m_filt = 1'b0; m_armed = 1'b0;
        m_edges = 0; m_cnt = '0; m_ovf = 1'b0;
    endtask

    task automatic model_edge(input logic l, input logic m);
        logic nf;
        nf = (m_lead[SYNC-1] == m_main[SYNC-1]) ? m_main[SYNC-1] : m_filt;
        if (m_armed && !m_filt && nf) begin
            if (m_cnt == '1) m_ovf = ~m_ovf;
            m_cnt = m_cnt + 1'b1;
        end
        if (m_edges == SYNC) m_armed = 1'b1;
        if (m_edges < SYNC) m_edges++;
        m_filt = nf;
        m_lead = {m_lead[SYNC-2:0], l};
        m_main = {m_main[SYNC-2:0], m};
    endtask

    task automatic check(input string req, input logic [CNT_W-1:0] exp_c,
                         input logic exp_o);
        checks++;
        if (wrap_count !== exp_c || wrap_ovf !== exp_o) begin
            failures++;
            $display("FAIL %s: count=%0d ovf=%0b expected count=%0d ovf=%0b",
                     req, wrap_count, wrap_ovf, exp_c, exp_o);
        end
    endtask

    // drive at falling edge, advance at rising edge, compare at falling edge
    task automatic step(input logic l, input logic m, input string req);
        tap_lead = l;
        tap_main = m;
        @(posedge clk);
        model_edge(l, m);
        @(negedge clk);
        check(req, m_cnt, m_ovf);
    endtask

    task automatic rotate(input string req);
        step(1'b1, 1'b0, req);
        step(1'b1, 1'b1, req);
        step(1'b0, 1'b1, req);
        step(1'b0, 1'b0, req);
    endtask

    task automatic do_reset(input logic l, input logic m);
        tap_lead = l;
        tap_main = m;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1", '0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] base;
        void'($urandom(32'd4711));

        // R1 and R7: taps high across reset, no count while priming
        do_reset(1'b1, 1'b1);
        step(1'b1, 1'b1, "R1");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R7");
        check("R7", '0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R7");
        check("R7", '0, 1'b0);

        // R2: latency of three edges
        base = wrap_count;
        tap_lead = 1'b1; tap_main = 1'b1;
        @(posedge clk); model_edge(1'b1, 1'b1); @(negedge clk);
        check("R2", base, 1'b0);
        @(posedge clk); model_edge(1'b1, 1'b1); @(negedge clk);
        check("R2", base, 1'b0);
        @(posedge clk); model_edge(1'b1, 1'b1); @(negedge clk);
        check("R2", base + 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R2");

        // R4: hovering patterns never count
        base = wrap_count;
        for (int i = 0; i < 20; i++) step(i[0], 1'b0, "R4");
        for (int i = 0; i < 20; i++) step(1'b0, i[0], "R4");
        check("R4", base, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R4");
        base = wrap_count;
        for (int i = 0; i < 20; i++) step(1'b1, i[0], "R4");
        for (int i = 0; i < 20; i++) step(i[0], 1'b1, "R4");
        check("R4", base, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R4");

        // R8: clean rotations add one each
        base = wrap_count;
        for (int i = 0; i < 5; i++) rotate("R8");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R8");
        check("R8", base + 5, 1'b0);

        // R6: full range of rotations wraps and toggles overflow
        base = wrap_count;
        for (int i = 0; i < (1 << CNT_W); i++) rotate("R6");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R6");
        check("R6", base, 1'b1);

        // R3 and R5: random tap pairs against the model
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] r;
            r = 2'($urandom_range(0, 3));
            step(r[1], r[0], (i % 2) ? "R3" : "R5");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule